// File: doc/BRIEF.md
# Clock Frequency Change Sequencer

This block carries out a safe change of the system clock frequency. A requester presents a target frequency in kHz together with a one-cycle request strobe. The block works out the PLL feedback multiplier from a fixed 16000 kHz reference and a fixed bus divider of 6. It then walks a fixed sequence: SDRAM into self refresh (when auto refresh is in use), system onto the low-power divided fallback clock, new multiplier loaded, fallback clock released, wait for PLL lock, SDRAM clock enable restored, and a settle period so the data-strobe capture logic can relock. It closes the exchange with a one-cycle acknowledge.

The analog PLL is outside the block and is seen only through its lock input. The block always reports the frequency the system currently runs at, so software or a neighbouring timer can track it. A request of zero only returns an acknowledge and leaves everything as it is. A request outside the legal range is acknowledged with a reject flag. If lock fails to arrive within a programmable number of cycles, the sequence completes anyway and raises an error flag.

Top module: `clk_switch_seq`

## Requirements
- R1: After reset, busy, req_ack, req_reject, limp_mode and lock_err are 0, sdram_cke is 1, pll_mfd is 120 and cur_khz is 80000.
- R2: A request of 0 kHz is acknowledged one cycle after the request edge with req_reject 0, and pll_mfd and cur_khz are left unchanged.
- R3: A request below 58333 kHz or above 80000 kHz is acknowledged one cycle after the request edge with req_reject 1, and pll_mfd is left unchanged.
- R4: For an accepted request f, the new multiplier is floor(24 × floor(100 × f / 16000) / 100), limited to the range 88 to 135. After the acknowledge, cur_khz equals floor(16000 × pll_mfd / 24).
- R5: When refresh_en is 1 at the request edge, sdram_cke goes low before the fallback clock is engaged and returns high after lock. When refresh_en is 0, sdram_cke stays high throughout.
- R6: pll_mfd changes only while limp_mode is 1. While limp_mode is 1, cur_khz reports 16000 >> (LIMP_CODE + 1), which is 4000 with the default code of 1.
- R7: After the fallback clock is released, the sequence holds until pll_lock is sampled high. Each extra cycle of waiting adds one cycle to the acknowledge latency.
- R8: With pll_lock already high, req_ack pulses for exactly one cycle, 519 clock edges after the request edge. This latency includes a 512-cycle settle period.
- R9: busy is 1 from the request edge until the acknowledge edge. A request made while busy is ignored: it produces no extra acknowledge and does not change the multiplier that is loaded.
- R10: If pll_lock stays low for lock_timeout + 1 wait cycles, lock_err is set and the sequence completes with lock_timeout extra cycles of latency. lock_err clears at the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_khz | input | 17 | Requested frequency in kHz |
| refresh_en | input | 1 | SDRAM auto refresh is active |
| pll_lock | input | 1 | PLL lock indication |
| lock_timeout | input | 16 | Maximum lock wait in cycles |
| req_ack | output | 1 | One-cycle completion pulse |
| req_reject | output | 1 | Request out of range, valid with req_ack |
| busy | output | 1 | Frequency change in progress |
| sdram_cke | output | 1 | SDRAM clock enable |
| limp_mode | output | 1 | System runs on the divided fallback clock |
| pll_mfd | output | 8 | PLL feedback multiplier |
| cur_khz | output | 17 | Current system frequency in kHz |
| lock_err | output | 1 | Lock did not arrive within the timeout |

## Verification
Zero and out-of-range requests are acknowledged one edge after the request edge. An accepted request is acknowledged 519 edges after it when lock is already present, later by exactly the number of extra lock-wait cycles otherwise. The bench counts edges from the request edge and samples one time unit after each edge, so every latency is compared as an exact number. The side effects (clock enable low, fallback clock seen with its 4000 kHz report, final multiplier and frequency) are sampled while that count runs.

// File: rtl/clk_switch_pkg.sv
package clk_switch_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SREF, S_LIMP, S_LOAD, S_UNLIMP, S_LOCK, S_RESTORE, S_SETTLE
  } seq_state_t;
endpackage

// File: rtl/clk_mfd_calc.sv
module clk_mfd_calc #(
  parameter int REF_KHZ  = 16000,
  parameter int BUS_DIV  = 6,
  parameter int MFD_MIN  = 88,
  parameter int MFD_MAX  = 135,
  parameter int FSYS_MIN = 58333,
  parameter int FSYS_MAX = 80000,
  parameter int FREQ_W   = 17,
  parameter int MFD_W    = 8
) (
  input  logic [FREQ_W-1:0] fsys_khz,
  output logic [MFD_W-1:0]  mfd,
  output logic              is_zero,
  output logic              in_range
);
  localparam int MULT = 4 * BUS_DIV;

  logic [31:0] scaled;
  logic [31:0] raw;

  always_comb begin
    scaled = (32'd100 * 32'(fsys_khz)) / 32'(REF_KHZ);
    raw    = (32'(MULT) * scaled) / 32'd100;
    if (raw < 32'(MFD_MIN))      mfd = MFD_W'(MFD_MIN);
    else if (raw > 32'(MFD_MAX)) mfd = MFD_W'(MFD_MAX);
    else                         mfd = raw[MFD_W-1:0];
    is_zero  = (fsys_khz == '0);
    in_range = (32'(fsys_khz) >= 32'(FSYS_MIN)) && (32'(fsys_khz) <= 32'(FSYS_MAX));
  end
endmodule

// File: rtl/clk_freq_report.sv
module clk_freq_report #(
  parameter int REF_KHZ   = 16000,
  parameter int BUS_DIV   = 6,
  parameter int LIMP_CODE = 1,
  parameter int FREQ_W    = 17,
  parameter int MFD_W     = 8
) (
  input  logic [MFD_W-1:0]  mfd,
  input  logic              limp,
  output logic [FREQ_W-1:0] khz
);
  localparam int LIMP_KHZ = REF_KHZ >> (LIMP_CODE + 1);

  logic [31:0] pll_khz;

  always_comb begin
    pll_khz = (32'(REF_KHZ) * 32'(mfd)) / 32'(4 * BUS_DIV);
    khz     = limp ? FREQ_W'(LIMP_KHZ) : FREQ_W'(pll_khz);
  end
endmodule

// File: rtl/clk_wait_ctr.sv
module clk_wait_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (clr)     count_d = '0;
    else if (en) count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/clk_switch_seq.sv
module clk_switch_seq
  import clk_switch_pkg::*;
#(
  parameter int REF_KHZ       = 16000,
  parameter int BUS_DIV       = 6,
  parameter int MFD_MIN       = 88,
  parameter int MFD_MAX       = 135,
  parameter int MFD_RESET     = 120,
  parameter int FSYS_MIN      = 58333,
  parameter int FSYS_MAX      = 80000,
  parameter int LIMP_CODE     = 1,
  parameter int SETTLE_CYCLES = 512,
  parameter int FREQ_W        = 17,
  parameter int MFD_W         = 8,
  parameter int CNT_W         = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [FREQ_W-1:0] req_khz,
  input  logic              refresh_en,
  input  logic              pll_lock,
  input  logic [CNT_W-1:0]  lock_timeout,
  output logic              req_ack,
  output logic              req_reject,
  output logic              busy,
  output logic              sdram_cke,
  output logic              limp_mode,
  output logic [MFD_W-1:0]  pll_mfd,
  output logic [FREQ_W-1:0] cur_khz,
  output logic              lock_err
);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  seq_state_t       state_q, state_d;
  logic             busy_q, busy_d, ack_q, ack_d, rej_q, rej_d;
  logic             cke_q, cke_d, limp_q, limp_d, err_q, err_d, sr_q, sr_d;
  logic [MFD_W-1:0] mfd_q, mfd_d, tgt_q, tgt_d, calc_mfd;
  logic             calc_zero, calc_ok, ctr_clr, ctr_en;
  logic [CNT_W-1:0] ctr;

  clk_mfd_calc #(
    .REF_KHZ(REF_KHZ), .BUS_DIV(BUS_DIV), .MFD_MIN(MFD_MIN), .MFD_MAX(MFD_MAX),
    .FSYS_MIN(FSYS_MIN), .FSYS_MAX(FSYS_MAX), .FREQ_W(FREQ_W), .MFD_W(MFD_W)
  ) u_calc (
    .fsys_khz(req_khz), .mfd(calc_mfd), .is_zero(calc_zero), .in_range(calc_ok)
  );

  clk_freq_report #(
    .REF_KHZ(REF_KHZ), .BUS_DIV(BUS_DIV), .LIMP_CODE(LIMP_CODE),
    .FREQ_W(FREQ_W), .MFD_W(MFD_W)
  ) u_report (
    .mfd(mfd_q), .limp(limp_q), .khz(cur_khz)
  );

  clk_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n_i), .clr(ctr_clr), .en(ctr_en), .count(ctr)
  );

  always_comb begin
    state_d = state_q;
    busy_d  = busy_q;
    ack_d   = 1'b0;
    rej_d   = 1'b0;
    cke_d   = cke_q;
    limp_d  = limp_q;
    err_d   = err_q;
    sr_d    = sr_q;
    mfd_d   = mfd_q;
    tgt_d   = tgt_q;
    ctr_clr = 1'b0;
    ctr_en  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          if (calc_zero) begin
            ack_d = 1'b1;
          end else if (!calc_ok) begin
            ack_d = 1'b1;
            rej_d = 1'b1;
          end else begin
            busy_d  = 1'b1;
            tgt_d   = calc_mfd;
            err_d   = 1'b0;
            sr_d    = refresh_en;
            state_d = S_SREF;
          end
        end
      end
      S_SREF: begin
        if (sr_q) cke_d = 1'b0;
        state_d = S_LIMP;
      end
      S_LIMP: begin
        limp_d  = 1'b1;
        state_d = S_LOAD;
      end
      S_LOAD: begin
        mfd_d   = tgt_q;
        state_d = S_UNLIMP;
      end
      S_UNLIMP: begin
        limp_d  = 1'b0;
        ctr_clr = 1'b1;
        state_d = S_LOCK;
      end
      S_LOCK: begin
        if (pll_lock) begin
          state_d = S_RESTORE;
        end else if (ctr >= lock_timeout) begin
          err_d   = 1'b1;
          state_d = S_RESTORE;
        end else begin
          ctr_en = 1'b1;
        end
      end
      S_RESTORE: begin
        cke_d   = 1'b1;
        ctr_clr = 1'b1;
        state_d = S_SETTLE;
      end
      S_SETTLE: begin
        if (ctr == SETTLE_LAST) begin
          ack_d   = 1'b1;
          busy_d  = 1'b0;
          state_d = S_IDLE;
        end else begin
          ctr_en = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= S_IDLE;
      busy_q  <= 1'b0;
      ack_q   <= 1'b0;
      rej_q   <= 1'b0;
      cke_q   <= 1'b1;
      limp_q  <= 1'b0;
      err_q   <= 1'b0;
      sr_q    <= 1'b0;
      mfd_q   <= MFD_W'(MFD_RESET);
      tgt_q   <= MFD_W'(MFD_RESET);
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      ack_q   <= ack_d;
      rej_q   <= rej_d;
      cke_q   <= cke_d;
      limp_q  <= limp_d;
      err_q   <= err_d;
      sr_q    <= sr_d;
      mfd_q   <= mfd_d;
      tgt_q   <= tgt_d;
    end
  end

  assign req_ack    = ack_q;
  assign req_reject = rej_q;
  assign busy       = busy_q;
  assign sdram_cke  = cke_q;
  assign limp_mode  = limp_q;
  assign pll_mfd    = mfd_q;
  assign lock_err   = err_q;

  // R9
  limp_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    limp_q |-> busy_q);
  // R5
  cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !cke_q |-> (busy_q && sr_q));
  // R4
  mfd_range_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mfd_q >= MFD_W'(MFD_MIN)) && (mfd_q <= MFD_W'(MFD_MAX)));
  // R6
  mfd_in_limp_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !$stable(mfd_q) |-> limp_q);
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ack_q |=> !ack_q);
  // R7
  restore_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q == S_RESTORE) |-> ($past(pll_lock) || err_q));
  // R10
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(err_q) |-> (state_q == S_RESTORE));
endmodule

// File: tb/test_clk_switch_seq.sv
module test_clk_switch_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  localparam int V_F   [NVEC] = '{80000, 66666, 70000, 58333, 60000, 58332, 80001};
  localparam int V_MFD [NVEC] = '{120,   99,    104,   88,    90,    0,     0};
  localparam int V_KHZ [NVEC] = '{80000, 66000, 69333, 58666, 60000, 0,     0};
  localparam bit V_REJ [NVEC] = '{0,     0,     0,     0,     0,     1,     1};

  logic        clk = 1'b0;
  logic        rst_n, req_valid, refresh_en, pll_lock;
  logic [16:0] req_khz;
  logic [15:0] lock_timeout;
  logic        req_ack, req_reject, busy, sdram_cke, limp_mode, lock_err;
  logic [7:0]  pll_mfd;
  logic [16:0] cur_khz;

  int total = 0;
  int bad = 0;
  int lat, acks;
  bit rej_seen, cke_low_seen, limp_seen, limp_khz_bad, busy_at_poke;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_switch_seq i_clk_switch_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_khz(req_khz),
    .refresh_en(refresh_en), .pll_lock(pll_lock), .lock_timeout(lock_timeout),
    .req_ack(req_ack), .req_reject(req_reject), .busy(busy), .sdram_cke(sdram_cke),
    .limp_mode(limp_mode), .pll_mfd(pll_mfd), .cur_khz(cur_khz), .lock_err(lock_err)
  );

  task automatic check(input string req, input int got, input int exp, input string what);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // one request; counts edges from the request edge until req_ack
  task automatic do_req(input int f, input int rise_at, input bit poke);
    @(negedge clk);
    req_valid = 1'b1;
    req_khz = 17'(f);
    lat = 0; rej_seen = 0; cke_low_seen = 0; limp_seen = 0;
    limp_khz_bad = 0; busy_at_poke = 0;
    while (lat < 3000) begin
      @(posedge clk);
      lat++;
      #1;
      if (lat == 1) req_valid = 1'b0;
      if (rise_at > 0 && lat == rise_at) pll_lock = 1'b1;
      if (poke && lat == 10) begin
        busy_at_poke = busy;
        req_valid = 1'b1;
        req_khz = 17'd60000;
      end
      if (poke && lat == 11) req_valid = 1'b0;
      if (!sdram_cke) cke_low_seen = 1;
      if (limp_mode) begin
        limp_seen = 1;
        if (cur_khz != 17'd4000) limp_khz_bad = 1;
      end
      if (req_ack) begin
        rej_seen = req_reject;
        break;
      end
    end
    acks = 0;
    repeat (4) begin
      @(posedge clk);
      #1;
      if (req_ack) acks++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int prev_mfd;
    rst_n = 1'b0; req_valid = 1'b0; req_khz = '0; refresh_en = 1'b1;
    pll_lock = 1'b1; lock_timeout = 16'd1000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", busy, 0, "busy");
    check("R1", req_ack, 0, "ack");
    check("R1", sdram_cke, 1, "cke");
    check("R1", limp_mode, 0, "limp");
    check("R1", lock_err, 0, "lock_err");
    check("R1", pll_mfd, 120, "mfd");
    check("R1", cur_khz, 80000, "khz");

    // R2 zero request
    do_req(0, 0, 0);
    check("R2", lat, 1, "zero latency");
    check("R2", rej_seen, 0, "zero reject");
    check("R2", pll_mfd, 120, "zero mfd");
    check("R2", cur_khz, 80000, "zero khz");

    // vector table: R3 R4 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      refresh_en = (i % 2 == 0);
      prev_mfd = pll_mfd;
      do_req(V_F[i], 0, 0);
      if (V_REJ[i]) begin
        check("R3", lat, 1, "reject latency");
        check("R3", rej_seen, 1, "reject flag");
        check("R3", pll_mfd, prev_mfd, "reject mfd");
      end else begin
        check("R8", lat, 519, "ack latency");
        check("R8", acks, 0, "extra ack");
        check("R3", rej_seen, 0, "accept flag");
        check("R4", pll_mfd, V_MFD[i], "mfd");
        check("R4", cur_khz, V_KHZ[i], "khz");
        check("R5", cke_low_seen, refresh_en, "cke low");
        check("R5", sdram_cke, 1, "cke restored");
        check("R6", limp_seen, 1, "limp seen");
        check("R6", limp_khz_bad, 0, "limp khz");
      end
    end

    // R7 lock arrives late: raised after edge 100, seen at edge 101
    refresh_en = 1'b1;
    @(negedge clk) pll_lock = 1'b0;
    do_req(70000, 100, 0);
    check("R7", lat, 614, "late lock latency");
    check("R7", lock_err, 0, "late lock err");
    check("R7", pll_mfd, 104, "late lock mfd");

    // R10 lock timeout
    @(negedge clk) begin pll_lock = 1'b0; lock_timeout = 16'd20; end
    do_req(80000, 0, 0);
    check("R10", lat, 539, "timeout latency");
    check("R10", lock_err, 1, "timeout err");
    check("R10", pll_mfd, 120, "timeout mfd");
    @(negedge clk) pll_lock = 1'b1;

    // R10 error clears at next accepted request; R9 request while busy ignored
    do_req(66666, 0, 1);
    check("R10", lock_err, 0, "err cleared");
    check("R9", busy_at_poke, 1, "busy mid switch");
    check("R9", lat, 519, "ignored req latency");
    check("R9", acks, 0, "ignored req ack");
    check("R9", pll_mfd, 99, "ignored req mfd");
    check("R9", busy, 0, "busy after ack");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule